// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Macrocell

This block is one output cell of a small programmable logic device. It receives eight product terms from the AND array, a clock, an active-low global output-enable pin and four configuration bits. Two bits are global and shared by every cell. Two bits are local to this cell. The cell combines the product terms into an OR sum and applies a polarity inversion. It then steers the result to its pad as a registered output, a combinational output, a combinational I/O, or nothing at all when the cell acts as a dedicated input. It also returns one feedback signal to the array.

The global bit `g_nreg` set to 1 removes registers from the device. In that case the clock and output-enable pins are offered to the array as ordinary inputs. The global bit `g_reg_fam` and the local bit `l_mode` drive the product-term, enable, output and feedback multiplexers. In the two end cells of the row (index 0 and the last index), `g_nreg` takes the place of `g_reg_fam` on the feedback multiplexer. That change removes their feedback in the dedicated-output arrangement. The register clears asynchronously on reset, and reset is released synchronously.

Top module: `pl_macrocell`

## Requirements
- R1: While reset is active, and until the first enabled clock edge after it, the register holds 0. In registered mode, `pad_out` and `fb_out` both read 0.
- R2: Registered mode is `g_nreg`=0, `g_reg_fam`=1, `l_mode`=0. On each rising clock edge the register loads (OR of all eight terms) XOR `l_invert`. `pad_out` and `fb_out` show the register output and do not change between edges.
- R3: `l_invert`=1 inverts the OR sum. `l_invert`=0 passes the sum unchanged. This holds both for the register input and for the combinational output.
- R4: In registered mode, `pad_oe` = NOT `oe_pin_n`.
- R5: Dedicated combinational output is `g_reg_fam`=0, `l_mode`=0. In this mode `pad_out` = (OR of all eight terms) XOR `l_invert` in the same cycle, with no clock delay, and `pad_oe`=1 whatever `oe_pin_n` is.
- R6: In dedicated-output mode, a cell that is not an end cell feeds back `adj_pin_in`. An end cell feeds back 0.
- R7: Dedicated input is `g_reg_fam`=0, `l_mode`=1. In this mode `pad_oe`=0, and `pad_out` still carries the polarity-adjusted sum of all eight terms. An interior cell feeds back `adj_pin_in`; an end cell feeds back its own `pin_in`.
- R8: Combinational I/O is `g_reg_fam`=1, `l_mode`=1, in either device kind. Term bit 0 drives `pad_oe`, and `pad_out` = (OR of term bits 7..1) XOR `l_invert`. Term bit 0 has no effect on `pad_out`, and `fb_out` = `pin_in`.
- R9: The register loads only while `g_nreg`=0. With `g_nreg`=1 it keeps its value across clock edges. With `g_reg_fam`=1 and `l_mode`=0, `pad_out` shows the held value.
- R10: With `g_nreg`=1, `array_clk` follows `clk` and `array_oe_n` follows `oe_pin_n`. With `g_nreg`=0 both are 0.
- R11: With `g_nreg`=1, `g_reg_fam`=1, `l_mode`=0, an interior cell feeds back the register and an end cell feeds back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock pin; the register loads on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pterm | input | NUM_PT | Product terms from the AND array |
| oe_pin_n | input | 1 | Global active-low output-enable pin |
| g_nreg | input | 1 | Global: 1 = device without registers |
| g_reg_fam | input | 1 | Global: 1 = registered-family arrangement |
| l_mode | input | 1 | Local mode select |
| l_invert | input | 1 | Local polarity: 1 = invert |
| pin_in | input | 1 | Level read back from this cell's own pin |
| adj_pin_in | input | 1 | Level read from the adjacent cell's pin |
| pad_out | output | 1 | Data toward the output buffer |
| pad_oe | output | 1 | Output buffer enable |
| fb_out | output | 1 | Feedback into the array |
| array_clk | output | 1 | Clock pin offered to the array as data |
| array_oe_n | output | 1 | OE pin offered to the array as data |

## Verification
The hardest case to reach is a register value that must stay put while the cell is configured without registers. The register is only visible at the pad in the registered arrangement, and the register becomes loadable again the moment that arrangement is restored. The stimulus loads a 1 in registered mode and sets `g_nreg` while `l_mode` stays 0. It then presents terms that would load a 0 and clocks several times. The held value stays visible at the pad, because the output multiplexer still selects the register. Running an interior cell and an end cell side by side exposes the end-cell feedback exception under identical inputs.

// File: rtl/plmc_pkg.sv
package plmc_pkg;

  // enable multiplexer choice, indexed by {g_reg_fam, l_mode}
  typedef enum logic [1:0] {
    OE_ALWAYS = 2'b00,
    OE_NEVER  = 2'b01,
    OE_GPIN   = 2'b10,
    OE_TERM   = 2'b11
  } oe_sel_e;

  typedef enum logic [1:0] {
    FB_NONE = 2'b00,
    FB_ADJ  = 2'b01,
    FB_PIN  = 2'b10,
    FB_REG  = 2'b11
  } fb_sel_e;

  // feedback choice from the steering bit and local mode
  function automatic fb_sel_e fb_pick(logic steer, logic mode, logic end_cell);
    fb_sel_e r;
    case ({steer, mode})
      2'b11:   r = FB_PIN;
      2'b10:   r = FB_REG;
      2'b01:   r = end_cell ? FB_PIN  : FB_ADJ;
      default: r = end_cell ? FB_NONE : FB_ADJ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/plmc_sum.sv
module plmc_sum #(
  parameter int NUM_PT = 8
) (
  input  logic [NUM_PT-1:0] pterm,
  input  logic              term_steal,
  input  logic              invert,
  output logic              sum_val,
  output logic              en_term
);
  logic [NUM_PT-1:0] gated;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PT; gi++) begin : g_gate
      if (gi == 0) begin : g_first
        assign gated[gi] = pterm[gi] & ~term_steal;
      end else begin : g_rest
        assign gated[gi] = pterm[gi];
      end
    end
  endgenerate

  assign sum_val = (|gated) ^ invert;
  assign en_term = pterm[0];

endmodule

// File: rtl/plmc_reg.sv
module plmc_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  // R9
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));

endmodule

// File: rtl/plmc_route.sv
module plmc_route
  import plmc_pkg::*;
#(
  parameter bit END_CELL = 1'b0
) (
  input  logic g_nreg,
  input  logic g_reg_fam,
  input  logic l_mode,
  input  logic oe_pin_n,
  input  logic sum_val,
  input  logic en_term,
  input  logic q,
  input  logic pin_in,
  input  logic adj_pin_in,
  output logic pad_out,
  output logic pad_oe,
  output logic fb_out
);
  logic    steer;
  oe_sel_e oe_sel;
  fb_sel_e fb_sel;

  generate
    if (END_CELL) begin : g_end
      assign steer = ~g_nreg;
    end else begin : g_mid
      assign steer = g_reg_fam;
    end
  endgenerate

  assign oe_sel = oe_sel_e'({g_reg_fam, l_mode});
  assign fb_sel = fb_pick(steer, l_mode, END_CELL);

  always_comb begin
    case (oe_sel)
      OE_ALWAYS: pad_oe = 1'b1;
      OE_NEVER:  pad_oe = 1'b0;
      OE_GPIN:   pad_oe = ~oe_pin_n;
      default:   pad_oe = en_term;
    endcase
  end

  always_comb begin
    pad_out = sum_val;
    if (g_reg_fam && !l_mode) pad_out = q;
  end

  always_comb begin
    case (fb_sel)
      FB_REG:  fb_out = q;
      FB_PIN:  fb_out = pin_in;
      FB_ADJ:  fb_out = adj_pin_in;
      default: fb_out = 1'b0;
    endcase
  end

endmodule

// File: rtl/pl_macrocell.sv
module pl_macrocell #(
  parameter int NUM_PT    = 8,
  parameter int NUM_CELLS = 8,
  parameter int CELL_IDX  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PT-1:0] pterm,
  input  logic              oe_pin_n,
  input  logic              g_nreg,
  input  logic              g_reg_fam,
  input  logic              l_mode,
  input  logic              l_invert,
  input  logic              pin_in,
  input  logic              adj_pin_in,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              fb_out,
  output logic              array_clk,
  output logic              array_oe_n
);
  localparam bit END_CELL = (CELL_IDX == 0) || (CELL_IDX == NUM_CELLS - 1);

  logic rst_s1, rst_sync;
  logic sum_val, en_term, q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  plmc_sum #(.NUM_PT(NUM_PT)) u_sum (
    .pterm      (pterm),
    .term_steal (g_reg_fam & l_mode),
    .invert     (l_invert),
    .sum_val    (sum_val),
    .en_term    (en_term)
  );

  plmc_reg u_reg (
    .clk   (clk),
    .rst_n (rst_sync),
    .en    (~g_nreg),
    .d     (sum_val),
    .q     (q)
  );

  plmc_route #(.END_CELL(END_CELL)) u_route (
    .g_nreg     (g_nreg),
    .g_reg_fam  (g_reg_fam),
    .l_mode     (l_mode),
    .oe_pin_n   (oe_pin_n),
    .sum_val    (sum_val),
    .en_term    (en_term),
    .q          (q),
    .pin_in     (pin_in),
    .adj_pin_in (adj_pin_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .fb_out     (fb_out)
  );

  assign array_clk  = clk & g_nreg;
  assign array_oe_n = oe_pin_n & g_nreg;

  // R2
  reg_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (!g_nreg && g_reg_fam && !l_mode) |=>
      (g_nreg || !g_reg_fam || l_mode || pad_out == $past(sum_val)));

  // R4
  reg_oe_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (g_reg_fam && !l_mode) |-> (pad_oe == !oe_pin_n));

  // R7
  din_off_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (!g_reg_fam && l_mode) |-> !pad_oe);

  // R8
  term_oe_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (g_reg_fam && l_mode) |-> (pad_oe == pterm[0] && fb_out == pin_in));

  // R10
  array_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    !g_nreg |-> (!array_oe_n && !array_clk));

  generate
    if (END_CELL) begin : g_end_chk
      // R6
      end_nofb_chk: assert property (@(posedge clk) disable iff (!rst_sync)
        (g_nreg && !l_mode) |-> !fb_out);
    end
  endgenerate

endmodule

// File: tb/tb_pl_macrocell.sv
module tb_pl_macrocell;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pterm;
  logic       oe_pin_n, g_nreg, g_reg_fam, l_mode, l_invert, pin_in, adj_pin_in;
  logic       pad_out, pad_oe, fb_out, array_clk, array_oe_n;
  logic       e_out, e_oe, e_fb, e_aclk, e_aoe;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  pl_macrocell #(.CELL_IDX(3)) dut (
    .clk(clk), .rst_n(rst_n), .pterm(pterm), .oe_pin_n(oe_pin_n),
    .g_nreg(g_nreg), .g_reg_fam(g_reg_fam), .l_mode(l_mode), .l_invert(l_invert),
    .pin_in(pin_in), .adj_pin_in(adj_pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .fb_out(fb_out), .array_clk(array_clk), .array_oe_n(array_oe_n));

  pl_macrocell #(.CELL_IDX(0)) dut_edge (
    .clk(clk), .rst_n(rst_n), .pterm(pterm), .oe_pin_n(oe_pin_n),
    .g_nreg(g_nreg), .g_reg_fam(g_reg_fam), .l_mode(l_mode), .l_invert(l_invert),
    .pin_in(pin_in), .adj_pin_in(adj_pin_in), .pad_out(e_out), .pad_oe(e_oe),
    .fb_out(e_fb), .array_clk(e_aclk), .array_oe_n(e_aoe));

  // {g_nreg, g_reg_fam, l_mode, l_invert, oe_pin_n, pin_in, adj_pin_in, pterm, exp{out,oe,fb_mid,fb_end}}
  localparam logic [18:0] VEC [12] = '{
    {1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,4'b0110},
    {1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h80,4'b1100},
    {1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,8'h01,4'b0110},
    {1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,4'b1100},
    {1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,8'hFF,4'b1010},
    {1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,8'h00,4'b0001},
    {1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,8'h01,4'b0111},
    {1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,8'h02,4'b1000},
    {1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,8'h03,4'b0111},
    {1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,8'h40,4'b1011},
    {1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,4'b1000},
    {1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h10,4'b1110}
  };

  task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic string mode_tag(logic fam, logic md);
    case ({fam, md})
      2'b00:   return "R3 R5 R6";
      2'b01:   return "R7";
      default: return "R3 R8";
    endcase
  endfunction

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pterm = 8'h00; oe_pin_n = 1'b0; g_nreg = 1'b0; g_reg_fam = 1'b1;
    l_mode = 1'b0; l_invert = 1'b0; pin_in = 1'b0; adj_pin_in = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(pad_out == 0 && fb_out == 0 && e_out == 0 && e_fb == 0, "R1",
          {pad_out, fb_out, e_out, e_fb}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    check(pad_out == 0 && fb_out == 0, "R1", {2'b00, pad_out, fb_out}, 4'b0000);

    // R4 enable from global pin
    oe_pin_n = 1'b0; #1;
    check(pad_oe == 1'b1, "R4", {3'b000, pad_oe}, 4'b0001);
    oe_pin_n = 1'b1; #1;
    check(pad_oe == 1'b0, "R4", {3'b000, pad_oe}, 4'b0000);

    // R2 load on rising edge only
    @(negedge clk);
    pterm = 8'h20; l_invert = 1'b0; #1;
    check(pad_out == 1'b0, "R2", {3'b000, pad_out}, 4'b0000);
    tick();
    check(pad_out == 1 && fb_out == 1 && e_fb == 1, "R2",
          {1'b0, pad_out, fb_out, e_fb}, 4'b0111);

    // R3 inversion into the register
    @(negedge clk);
    l_invert = 1'b1;
    tick();
    check(pad_out == 1'b0, "R3", {3'b000, pad_out}, 4'b0000);
    @(negedge clk);
    pterm = 8'h00;
    tick();
    check(pad_out == 1'b1, "R3", {3'b000, pad_out}, 4'b0001);

    // R9 hold with registers disallowed; R11 feedback split; R10 pins to array
    @(negedge clk);
    g_nreg = 1'b1; pterm = 8'h20; l_invert = 1'b1; oe_pin_n = 1'b1;
    repeat (3) tick();
    check(pad_out == 1'b1, "R9", {3'b000, pad_out}, 4'b0001);
    check(fb_out == 1'b1 && e_fb == 1'b0, "R11", {2'b00, fb_out, e_fb}, 4'b0010);
    check(array_oe_n == 1'b1, "R10", {3'b000, array_oe_n}, 4'b0001);
    @(posedge clk); #1;
    check(array_clk == 1'b1, "R10", {3'b000, array_clk}, 4'b0001);
    @(negedge clk); #1;
    check(array_clk == 1'b0, "R10", {3'b000, array_clk}, 4'b0000);
    g_nreg = 1'b0;
    @(posedge clk); #1;
    check(array_clk == 1'b0 && array_oe_n == 1'b0, "R10",
          {2'b00, array_clk, array_oe_n}, 4'b0000);
    check(pad_out == 1'b0, "R2", {3'b000, pad_out}, 4'b0000);

    // table of combinational arrangements
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      {g_nreg, g_reg_fam, l_mode, l_invert, oe_pin_n, pin_in, adj_pin_in, pterm} = VEC[i][18:4];
      #1;
      check({pad_out, pad_oe, fb_out, e_fb} == VEC[i][3:0], mode_tag(g_reg_fam, l_mode),
            {pad_out, pad_oe, fb_out, e_fb}, VEC[i][3:0]);
    end

    // R8 term bit 0 does not reach the output
    @(negedge clk);
    g_nreg = 1'b1; g_reg_fam = 1'b1; l_mode = 1'b1; l_invert = 1'b0; pterm = 8'h00; #1;
    check(pad_out == 1'b0, "R8", {3'b000, pad_out}, 4'b0000);
    pterm = 8'h01; #1;
    check(pad_out == 1'b0 && pad_oe == 1'b1, "R8", {2'b00, pad_out, pad_oe}, 4'b0001);

    // R5 no clock delay in dedicated output
    g_reg_fam = 1'b0; l_mode = 1'b0; pterm = 8'h04; oe_pin_n = 1'b1; #1;
    check(pad_out == 1'b1 && pad_oe == 1'b1, "R5", {2'b00, pad_out, pad_oe}, 4'b0011);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule